// File: doc/BRIEF.md
# Multi-line interrupt vector arbiter

This block collects interrupt requests from a bank of serial lines and turns them into two master requests and two vectors. Each line can raise three kinds of request: receive, dataset change and transmit. Receive and dataset-change requests feed the receive-side master request. Transmit requests feed the transmit-side master request. Per-line set and clear strobes update the pending bits.

When the bus side acknowledges a master request, the arbiter picks the lowest-numbered line with a pending request on that side. It registers that line's vector, base plus eight times the line number, and drops the line's pending bits. Each line occupies an 8-byte register window, which is why the vector stride is eight. The receive and dataset requests of a line share one vector and are retired together. The transmit vector sits 4 above the receive vector of the same line.

The number of lines is a parameter from 1 to 16.

Top module: `irq_vector_arb`

## Requirements
- R1: After reset no request is pending. Both master requests are 0 and both vector outputs are 0.
- R2: `rx_irq` is 1 exactly while at least one line has a receive or a dataset-change request pending. A set strobe on any line makes it 1 in the following cycle.
- R3: `tx_irq` is 1 exactly while at least one line has a transmit request pending. A set strobe on any line makes it 1 in the following cycle.
- R4: Take the lowest line L with a receive or dataset request pending when `rx_ack` is high. The cycle after the acknowledge, `rx_vec` equals `base_vec + 8*L`, using the `base_vec` value present at the acknowledge.
- R5: A receive-side acknowledge clears both the receive and the dataset-change request of the winning line. It leaves the requests of every other line untouched, and it leaves all transmit requests untouched.
- R6: Take the lowest line L with a transmit request pending when `tx_ack` is high. The cycle after the acknowledge, `tx_vec` equals `base_vec + 8*L + 4`. Only that line's transmit request is cleared, and receive and dataset requests are unaffected.
- R7: An acknowledge on a side with nothing pending loads 0 into that side's vector output.
- R8: A clear strobe removes only its own request type on its own line. For example, clearing the receive request of a line leaves that line's dataset request pending.
- R9: When a set and a clear for the same bit arrive in the same cycle, the bit ends up set. This also holds when the clear comes from an acknowledge.
- R10: Each vector output holds its value in every cycle without an acknowledge on its side, even if `base_vec` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_set | input | LINES | Per-line receive request set strobes |
| rx_clr | input | LINES | Per-line receive request clear strobes |
| ds_set | input | LINES | Per-line dataset-change request set strobes |
| ds_clr | input | LINES | Per-line dataset-change request clear strobes |
| tx_set | input | LINES | Per-line transmit request set strobes |
| tx_clr | input | LINES | Per-line transmit request clear strobes |
| base_vec | input | VW | Vector of line 0 |
| rx_ack | input | 1 | Receive-side acknowledge strobe |
| tx_ack | input | 1 | Transmit-side acknowledge strobe |
| rx_irq | output | 1 | Receive-side master request |
| tx_irq | output | 1 | Transmit-side master request |
| rx_vec | output | VW | Registered receive-side vector |
| tx_vec | output | VW | Registered transmit-side vector |

## Verification
The bench pends requests on scattered lines and acknowledges repeatedly, checking that the lines come out in ascending order. A design with a reversed priority encoder would return the highest line first.

One line is given both a receive and a dataset request. A design that clears only one of the two would hand out that line's vector a second time. Transmit acknowledges are interleaved with pending receive requests, which exposes cross-clearing between the two sides and a missing offset of 4.

Set and clear strobes, and a set together with an acknowledge, are applied in the same cycle. A clear-priority merge would lose these requests. A final test changes the base while idle and checks that the vector stays put, which catches a combinational vector output.

// File: rtl/irq_vector_arb.sv
module irq_vector_arb #(
  parameter int LINES = 16,
  parameter int VW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] rx_set,
  input  logic [LINES-1:0] rx_clr,
  input  logic [LINES-1:0] ds_set,
  input  logic [LINES-1:0] ds_clr,
  input  logic [LINES-1:0] tx_set,
  input  logic [LINES-1:0] tx_clr,
  input  logic [VW-1:0]    base_vec,
  input  logic             rx_ack,
  input  logic             tx_ack,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic [VW-1:0]    rx_vec,
  output logic [VW-1:0]    tx_vec
);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;

  logic [LINES-1:0] rx_q, ds_q, tx_q;
  logic [LINES-1:0] rx_any, rx_win, tx_win;
  logic [LW-1:0]    rx_idx, tx_idx;
  logic             rx_hit, tx_hit;

  assign rx_any = rx_q | ds_q;
  assign rx_irq = |rx_any;
  assign tx_irq = |tx_q;

  always_comb begin
    rx_hit = 1'b0;
    rx_idx = '0;
    tx_hit = 1'b0;
    tx_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (rx_any[i]) begin
        rx_hit = 1'b1;
        rx_idx = LW'(i);
      end
      if (tx_q[i]) begin
        tx_hit = 1'b1;
        tx_idx = LW'(i);
      end
    end
  end

  assign rx_win = (rx_ack && rx_hit) ? (LINES'(1) << rx_idx) : '0;
  assign tx_win = (tx_ack && tx_hit) ? (LINES'(1) << tx_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q   <= '0;
      ds_q   <= '0;
      tx_q   <= '0;
      rx_vec <= '0;
      tx_vec <= '0;
    end else begin
      rx_q <= (rx_q & ~rx_clr & ~rx_win) | rx_set;
      ds_q <= (ds_q & ~ds_clr & ~rx_win) | ds_set;
      tx_q <= (tx_q & ~tx_clr & ~tx_win) | tx_set;
      if (rx_ack)
        rx_vec <= rx_hit ? base_vec + (VW'(rx_idx) << 3) : '0;
      if (tx_ack)
        tx_vec <= tx_hit ? base_vec + (VW'(tx_idx) << 3) + VW'(4) : '0;
    end
  end
endmodule

// File: rtl/irq_vector_arb_chk.sv
module irq_vector_arb_chk #(
  parameter int LINES = 16,
  parameter int VW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] rx_set,
  input logic [LINES-1:0] ds_set,
  input logic [LINES-1:0] tx_set,
  input logic [VW-1:0]    base_vec,
  input logic             rx_ack,
  input logic             tx_ack,
  input logic             rx_irq,
  input logic             tx_irq,
  input logic [VW-1:0]    rx_vec,
  input logic [VW-1:0]    tx_vec
);
  p_rx_set_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rx_set | ds_set)) |=> rx_irq);

  p_tx_set_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_set) |=> tx_irq);

  p_rx_vec_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && rx_irq) |=> ((rx_vec - $past(base_vec)) & VW'(7)) == '0);

  p_tx_vec_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && tx_irq) |=> ((tx_vec - $past(base_vec)) & VW'(7)) == VW'(4));

  p_rx_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !rx_irq) |=> rx_vec == '0);

  p_tx_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && !tx_irq) |=> tx_vec == '0);

  p_rx_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ack |=> $stable(rx_vec));

  p_tx_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ack |=> $stable(tx_vec));
endmodule

bind irq_vector_arb irq_vector_arb_chk #(.LINES(LINES), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_set(rx_set), .ds_set(ds_set), .tx_set(tx_set),
  .base_vec(base_vec), .rx_ack(rx_ack), .tx_ack(tx_ack), .rx_irq(rx_irq),
  .tx_irq(tx_irq), .rx_vec(rx_vec), .tx_vec(tx_vec)
);

// File: tb/irq_vector_arb_tb.sv
module irq_vector_arb_tb_top;
  localparam int LINES = 16;
  localparam int VW    = 16;
  localparam logic [VW-1:0] BASE = 16'h00C0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LINES-1:0] rx_set = '0, rx_clr = '0, ds_set = '0, ds_clr = '0, tx_set = '0, tx_clr = '0;
  logic [VW-1:0] base_vec = BASE;
  logic rx_ack = 1'b0, tx_ack = 1'b0;
  logic rx_irq, tx_irq;
  logic [VW-1:0] rx_vec, tx_vec;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_arb #(.LINES(LINES), .VW(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_set(rx_set), .rx_clr(rx_clr), .ds_set(ds_set),
    .ds_clr(ds_clr), .tx_set(tx_set), .tx_clr(tx_clr), .base_vec(base_vec),
    .rx_ack(rx_ack), .tx_ack(tx_ack), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .rx_vec(rx_vec), .tx_vec(tx_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    rx_set = '0; rx_clr = '0; ds_set = '0; ds_clr = '0; tx_set = '0; tx_clr = '0;
    rx_ack = 1'b0; tx_ack = 1'b0;
  endtask

  task automatic rx_take(input string req, input logic [VW-1:0] exp);
    rx_ack = 1'b1; tick();
    chk(req, rx_vec, exp);
  endtask

  task automatic tx_take(input string req, input logic [VW-1:0] exp);
    tx_ack = 1'b1; tick();
    chk(req, tx_vec, exp);
  endtask

  task automatic t_reset();
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 rx_vec", rx_vec, 0);
    chk("R1 tx_vec", tx_vec, 0);
  endtask

  task automatic t_priority();
    rx_set[5] = 1; rx_set[9] = 1; ds_set[3] = 1; tick();
    chk("R2 rx_irq on", rx_irq, 1);
    chk("R3 tx_irq off", tx_irq, 0);
    rx_take("R4 line3", BASE + 24);
    rx_take("R4 line5", BASE + 40);
    rx_take("R4 line9", BASE + 72);
    chk("R2 rx_irq drained", rx_irq, 0);
    rx_take("R7 rx empty", 0);
  endtask

  task automatic t_shared_clear();
    rx_set[2] = 1; ds_set[2] = 1; ds_set[7] = 1; tick();
    rx_take("R5 line2", BASE + 16);
    rx_take("R5 line7 next", BASE + 56);
    chk("R5 both cleared", rx_irq, 0);
  endtask

  task automatic t_tx();
    tx_set[0] = 1; tx_set[15] = 1; rx_set[0] = 1; tick();
    chk("R3 tx_irq on", tx_irq, 1);
    tx_take("R6 line0", BASE + 4);
    chk("R6 tx still pending", tx_irq, 1);
    tx_take("R6 line15", BASE + 124);
    chk("R3 tx_irq drained", tx_irq, 0);
    chk("R6 rx untouched", rx_irq, 1);
    rx_take("R5 rx line0 kept", BASE);
    tx_take("R7 tx empty", 0);
  endtask

  task automatic t_clear();
    rx_set[4] = 1; ds_set[4] = 1; tick();
    rx_clr[4] = 1; tick();
    chk("R8 ds survives rx clr", rx_irq, 1);
    ds_clr[4] = 1; tick();
    chk("R8 ds cleared", rx_irq, 0);
    rx_set[4] = 1; ds_set[6] = 1; tx_set[1] = 1; tick();
    ds_clr[6] = 1; tx_clr[1] = 1; tick();
    chk("R8 tx cleared", tx_irq, 0);
    rx_take("R8 line4 kept", BASE + 32);
    chk("R8 line6 gone", rx_irq, 0);
  endtask

  task automatic t_set_wins();
    rx_set[1] = 1; rx_clr[1] = 1; tick();
    chk("R9 set beats clear", rx_irq, 1);
    rx_take("R9 line1", BASE + 8);
    ds_set[3] = 1; tick();
    rx_ack = 1; ds_set[3] = 1; tick();
    chk("R9 ack vec", rx_vec, BASE + 24);
    chk("R9 set beats ack", rx_irq, 1);
    rx_take("R9 line3 again", BASE + 24);
    tx_set[2] = 1; tx_clr[2] = 1; tick();
    chk("R9 tx set beats clear", tx_irq, 1);
    tx_take("R9 tx line2", BASE + 20);
  endtask

  task automatic t_hold();
    rx_set[10] = 1; tick();
    rx_take("R4 line10", BASE + 80);
    base_vec = 16'h0200;
    tick(); tick();
    chk("R10 rx hold", rx_vec, BASE + 80);
    chk("R10 tx hold", tx_vec, BASE + 20);
    rx_take("R7 new base empty", 0);
    tx_set[6] = 1; tick();
    tx_take("R6 new base", 16'h0200 + 52);
    base_vec = BASE;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_shared_clear();
    t_tx();
    t_clear();
    t_set_wins();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule